// File: doc/BRIEF.md
# Two-Channel Bias Fast-Charge Relay Sequencer

This block loads a new bias setpoint into a heavily filtered RC bias node without waiting hours for the node to settle. Each channel owns a bypass relay. When closed, the relay puts a small resistor across the filter resistor and makes the time constant short. A command picks a channel and supplies a 12-bit setpoint, a contact-settle delay and a settle interval, all counted in clock cycles. The channel then runs a fixed sequence. It closes the relay and waits for the contacts. It strobes the setpoint into the converter and waits the settle interval. It opens the relay, waits for the contacts again, and reports completion.

Channel 0 drives the device gate bias and channel 1 drives the amplifier offset bias. The two channels run independently of each other. They share a single registered converter load port, which carries a channel select and the code. If both channels ask for the port in the same cycle, a fixed priority decides which one goes first. A command aimed at a channel that is still busy is dropped, and that channel's reject flag is set. Once a channel has released its relay, its converter output is not written again until the next accepted command.

Top module: `bias_charge_seq`

## Requirements
- R1: An accepted start (cmd_start high, cmd_chan naming a channel whose busy is low) closes that channel's relay_close bit and raises its busy bit at the clock edge that samples it.
- R2: Counting from the edge where the relay closes, the converter load strobe (dac_load high for one cycle) appears C+3 cycles later, where C is the contact delay latched with the command. dac_load is only ever high while the selected channel's relay is closed.
- R3: The relay opens exactly S+1 cycles after the edge that raises the load strobe, where S is the latched settle interval.
- R4: The done bit for the channel is a single-cycle pulse that starts C+2 cycles after the relay opens. Busy stays high for 2C+S+7 cycles in total.
- R5: Each accepted command gives exactly one load strobe. It carries dac_sel equal to the channel index (0 for gate bias, 1 for offset bias) and dac_code equal to the commanded value.
- R6: A start aimed at a busy channel is ignored and sets that channel's busy_reject bit. The running sequence keeps its original value and timing.
- R7: busy_reject for a channel clears at the next accepted start on that channel.
- R8: A start on an idle channel is accepted while the other channel is busy, and both sequences complete with correct codes.
- R9: When both channels request the converter in the same cycle, channel 0 is strobed first and channel 1 is strobed on the next cycle. Channel 1's settle interval then counts from its own strobe.
- R10: While reset is asserted, every relay is open, busy and done are low, and dac_load is low. A reset in the middle of a sequence aborts it.
- R11: Delay and value inputs are latched when a command is accepted. Later changes on those inputs do not affect a sequence that is already running.
- R12: An idle channel sees no load strobe. After release, the converter value stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command strobe |
| cmd_chan | input | 1 | Target channel (0 gate, 1 offset) |
| cmd_value | input | 12 | Bias setpoint code |
| cmd_contact | input | 16 | Relay contact-settle delay in cycles |
| cmd_settle | input | 24 | Settle interval with relay closed, in cycles |
| relay_close | output | 2 | Per-channel bypass relay drive, 1 = closed |
| dac_load | output | 1 | Converter load strobe |
| dac_sel | output | 1 | Converter channel for the strobe |
| dac_code | output | 12 | Converter code for the strobe |
| busy | output | 2 | Per-channel sequence in progress |
| done | output | 2 | Per-channel completion pulse |
| busy_reject | output | 2 | Per-channel sticky flag for a rejected start |

## Verification
The bench builds the block with its default widths: two channels, 12-bit codes, a 16-bit contact delay and a 24-bit settle counter. It programs delays of only a few to a few tens of cycles, so every phase boundary can be timed exactly against the closed-form cycle counts. Giving the two channels different contact delays lets the bench line up their converter requests in the same cycle, which exercises the priority path. The full-width counters are exercised through their countdown assertion, not through long runs.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLOSE  = 3'd1,
    ST_WAIT_C = 3'd2,
    ST_LOAD   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_OPEN   = 3'd5,
    ST_WAIT_O = 3'd6,
    ST_FINISH = 3'd7
  } seq_state_e;

  // relay is held closed from the close step through the settle wait
  function automatic logic relay_held(input seq_state_e s);
    return (s == ST_CLOSE) || (s == ST_WAIT_C) || (s == ST_LOAD) || (s == ST_SETTLE);
  endfunction

  // a wait step that ends when the shared timer reaches zero
  function automatic logic timed_step(input seq_state_e s);
    return (s == ST_WAIT_C) || (s == ST_SETTLE) || (s == ST_WAIT_O);
  endfunction

  function automatic logic [2:0] step_after_timer(input seq_state_e s);
    case (s)
      ST_WAIT_C: return ST_LOAD;
      ST_SETTLE: return ST_OPEN;
      default:   return ST_FINISH;
    endcase
  endfunction

endpackage

// File: rtl/bias_seq_timer.sv
module bias_seq_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: an unloaded nonzero timer steps down by exactly one per cycle
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/bias_seq_chan.sv
module bias_seq_chan
  import bias_seq_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 16,
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] value,
  input  logic [CW-1:0] contact,
  input  logic [SW-1:0] settle,
  input  logic          grant,
  output logic          req,
  output logic [DW-1:0] code,
  output logic          relay,
  output logic          busy_o,
  output logic          done_o,
  output logic          reject_o
);
  localparam int TW = (SW > CW) ? SW : CW;

  seq_state_e    state, state_nx;
  logic [DW-1:0] val_q;
  logic [CW-1:0] contact_q;
  logic [SW-1:0] settle_q;
  logic          rej_q;
  logic          accept, refuse;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;

  // named events for the assertions
  assign accept = start && (state == ST_IDLE);
  assign refuse = start && (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = TW'(contact_q);
    case (state)
      ST_IDLE:  if (accept) state_nx = ST_CLOSE;
      ST_CLOSE: begin tmr_load = 1'b1; state_nx = ST_WAIT_C; end
      ST_LOAD:  if (grant) begin
                  tmr_load = 1'b1;
                  tmr_val  = TW'(settle_q);
                  state_nx = ST_SETTLE;
                end
      ST_OPEN:  begin tmr_load = 1'b1; state_nx = ST_WAIT_O; end
      ST_FINISH: state_nx = ST_IDLE;
      default:  if (timed_step(state) && tmr_expired)
                  state_nx = seq_state_e'(step_after_timer(state));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      val_q     <= '0;
      contact_q <= '0;
      settle_q  <= '0;
      rej_q     <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        val_q     <= value;
        contact_q <= contact;
        settle_q  <= settle;
        rej_q     <= 1'b0;
      end else if (refuse) begin
        rej_q <= 1'b1;
      end
    end
  end

  bias_seq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  assign req      = (state == ST_LOAD);
  assign code     = val_q;
  assign relay    = relay_held(state);
  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_FINISH);
  assign reject_o = rej_q;

  // R6: a refused start leaves the running sequence and its value alone
  a_r6_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && state != ST_FINISH) |=> (busy_o && $stable(val_q)));

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: the converter request only follows a closed relay
  a_r2_req_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(relay));

endmodule

// File: rtl/bias_load_arb.sv
module bias_load_arb #(
  parameter int NCH  = 2,
  parameter int DW   = 12,
  parameter int SELW = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          req,
  input  logic [NCH-1:0][DW-1:0]  codes,
  input  logic [NCH-1:0]          relay,
  output logic [NCH-1:0]          grant,
  output logic                    dac_load,
  output logic [SELW-1:0]         dac_sel,
  output logic [DW-1:0]           dac_code
);

  // lowest index wins
  always_comb begin
    grant = '0;
    for (int i = 0; i < NCH; i++)
      if (req[i] && grant == '0) grant[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_load <= 1'b0;
      dac_sel  <= '0;
      dac_code <= '0;
    end else begin
      dac_load <= |grant;
      for (int i = 0; i < NCH; i++)
        if (grant[i]) begin
          dac_sel  <= SELW'(i);
          dac_code <= codes[i];
        end
    end
  end

  // R9: at most one channel granted per cycle
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: a converter strobe never lands on a channel with an open relay
  a_r2_load_needs_relay: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> relay[dac_sel]);

endmodule

// File: rtl/bias_charge_seq.sv
module bias_charge_seq #(
  parameter int NCH = 2,
  parameter int DW  = 12,
  parameter int CW  = 16,
  parameter int SW  = 24,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic [SELW-1:0] cmd_chan,
  input  logic [DW-1:0]   cmd_value,
  input  logic [CW-1:0]   cmd_contact,
  input  logic [SW-1:0]   cmd_settle,
  output logic [NCH-1:0]  relay_close,
  output logic            dac_load,
  output logic [SELW-1:0] dac_sel,
  output logic [DW-1:0]   dac_code,
  output logic [NCH-1:0]  busy,
  output logic [NCH-1:0]  done,
  output logic [NCH-1:0]  busy_reject
);

  logic [NCH-1:0]         start_v, req_v, grant_v;
  logic [NCH-1:0][DW-1:0] code_v;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign start_v[ch] = cmd_start && (cmd_chan == SELW'(ch));

    bias_seq_chan #(.DW(DW), .CW(CW), .SW(SW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_v[ch]),
      .value   (cmd_value),
      .contact (cmd_contact),
      .settle  (cmd_settle),
      .grant   (grant_v[ch]),
      .req     (req_v[ch]),
      .code    (code_v[ch]),
      .relay   (relay_close[ch]),
      .busy_o  (busy[ch]),
      .done_o  (done[ch]),
      .reject_o(busy_reject[ch])
    );
  end

  bias_load_arb #(.NCH(NCH), .DW(DW), .SELW(SELW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_v),
    .codes   (code_v),
    .relay   (relay_close),
    .grant   (grant_v),
    .dac_load(dac_load),
    .dac_sel (dac_sel),
    .dac_code(dac_code)
  );

  // R10: the first cycle out of reset has every relay open and no strobe
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (relay_close == '0 && !dac_load));

endmodule

// File: tb/bias_charge_seq_bench.sv
module bias_charge_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic        cmd_chan = 1'b0;
  logic [11:0] cmd_value = '0;
  logic [15:0] cmd_contact = '0;
  logic [23:0] cmd_settle = '0;
  logic [1:0]  relay_close, busy, done, busy_reject;
  logic        dac_load, dac_sel;
  logic [11:0] dac_code;

  always #2 clk = ~clk;

  bias_charge_seq u_bias_charge_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_chan(cmd_chan),
    .cmd_value(cmd_value), .cmd_contact(cmd_contact), .cmd_settle(cmd_settle),
    .relay_close(relay_close), .dac_load(dac_load), .dac_sel(dac_sel),
    .dac_code(dac_code), .busy(busy), .done(done), .busy_reject(busy_reject)
  );

  int cyc = 0, errs = 0, checks = 0;
  int t_rise[2], t_fall[2], t_load[2], t_done[2], t_bfall[2], n_load[2];
  logic [11:0] c_load[2];
  logic prev_rel[2], prev_busy[2];

  always @(posedge clk) cyc <= cyc + 1;

  // event log sampled away from the active edge
  initial begin
    for (int i = 0; i < 2; i++) begin n_load[i] = 0; prev_rel[i] = 0; prev_busy[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        if (relay_close[i] && !prev_rel[i]) t_rise[i] = cyc;
        if (!relay_close[i] && prev_rel[i]) t_fall[i] = cyc;
        if (done[i]) t_done[i] = cyc;
        if (!busy[i] && prev_busy[i]) t_bfall[i] = cyc;
        prev_rel[i] = relay_close[i];
        prev_busy[i] = busy[i];
      end
      if (dac_load) begin
        t_load[dac_sel] = cyc;
        c_load[dac_sel] = dac_code;
        n_load[dac_sel] = n_load[dac_sel] + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_cmd(input int ch, input logic [11:0] v, input int c, input int s, output int e);
    @(negedge clk);
    cmd_start = 1'b1; cmd_chan = ch[0]; cmd_value = v;
    cmd_contact = c[15:0]; cmd_settle = s[23:0];
    @(negedge clk);
    cmd_start = 1'b0;
    e = cyc;
  endtask

  task automatic wait_idle(input int ch);
    int n = 0;
    while (busy[ch] && n < 20000) begin @(negedge clk); n++; end
    chk("R4 sequence completes", int'(n < 20000), 1);
    repeat (2) @(negedge clk);
  endtask

  // closed-form expectations written from the requirements
  function automatic int lag_load(input int c);           return c + 3; endfunction
  function automatic int busy_len(input int c, input int s); return (c + 2) + (s + 1) + (c + 4); endfunction

  task automatic check_seq(input int ch, input int e, input logic [11:0] v, input int c, input int s, input int nl);
    chk("R1 relay closes at accept edge", t_rise[ch], e);
    chk("R2 load lag after relay close", t_load[ch] - t_rise[ch], lag_load(c));
    chk("R5 load code", int'(c_load[ch]), int'(v));
    chk("R5 one load per command", n_load[ch] - nl, 1);
    chk("R3 relay open after settle", t_fall[ch] - t_load[ch], s + 1);
    chk("R4 done after relay open", t_done[ch] - t_fall[ch], c + 2);
    chk("R4 busy length", t_bfall[ch] - e, busy_len(c, s));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R10 relays open in reset", int'(relay_close), 0);
    chk("R10 busy low in reset", int'(busy), 0);
    chk("R10 no load in reset", int'(dac_load), 0);
    chk("R10 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single(input int ch, input logic [11:0] v, input int c, input int s);
    int e, nl;
    nl = n_load[ch];
    start_cmd(ch, v, c, s, e);
    chk("R1 relay closed after accept", int'(relay_close[ch]), 1);
    chk("R1 busy after accept", int'(busy[ch]), 1);
    wait_idle(ch);
    check_seq(ch, e, v, c, s, nl);
  endtask

  task automatic t_reject;
    int e, e2, nl;
    nl = n_load[0];
    start_cmd(0, 12'h5A3, 2, 10, e);
    repeat (2) @(negedge clk);
    start_cmd(0, 12'h0F0, 7, 50, e2);   // R6, R11: inputs now differ
    chk("R6 reject flag set", int'(busy_reject[0]), 1);
    chk("R6 other channel flag clear", int'(busy_reject[1]), 0);
    wait_idle(0);
    check_seq(0, e, 12'h5A3, 2, 10, nl);
    chk("R6 flag stays until next accept", int'(busy_reject[0]), 1);
    start_cmd(0, 12'h111, 1, 3, e2);
    chk("R7 flag cleared on accept", int'(busy_reject[0]), 0);
    wait_idle(0);
  endtask

  task automatic t_indep;
    int e0, e1, n0, n1;
    n0 = n_load[0]; n1 = n_load[1];
    start_cmd(0, 12'hABC, 3, 30, e0);
    start_cmd(1, 12'h123, 2, 8, e1);
    chk("R8 channel 0 still busy", int'(busy[0]), 1);
    chk("R8 channel 1 accepted", int'(busy[1]), 1);
    chk("R8 no reject on idle channel", int'(busy_reject[1]), 0);
    wait_idle(0);
    wait_idle(1);
    check_seq(0, e0, 12'hABC, 3, 30, n0);
    check_seq(1, e1, 12'h123, 2, 8, n1);
  endtask

  task automatic t_contend;
    int e0, e1;
    start_cmd(1, 12'h777, 6, 12, e1);
    start_cmd(0, 12'h888, 4, 12, e0);   // both request the converter together
    wait_idle(1);
    wait_idle(0);
    chk("R9 channel 0 strobed first", t_load[0] - e0, lag_load(4));
    chk("R9 channel 1 one cycle later", t_load[1] - t_load[0], 1);
    chk("R9 channel 0 code", int'(c_load[0]), int'(12'h888));
    chk("R9 channel 1 code", int'(c_load[1]), int'(12'h777));
    chk("R9 channel 1 settle from own strobe", t_fall[1] - t_load[1], 13);
  endtask

  task automatic t_frozen;
    int n0, n1;
    n0 = n_load[0]; n1 = n_load[1];
    cmd_value = 12'hFFF; cmd_contact = 16'd1; cmd_settle = 24'd1;
    repeat (100) @(negedge clk);
    chk("R12 no strobe on idle channel 0", n_load[0] - n0, 0);
    chk("R12 no strobe on idle channel 1", n_load[1] - n1, 0);
    chk("R12 relays stay open", int'(relay_close), 0);
  endtask

  task automatic t_abort;
    int e;
    start_cmd(1, 12'h321, 5, 40, e);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 abort opens relay", int'(relay_close), 0);
    chk("R10 abort clears busy", int'(busy), 0);
    chk("R10 abort no strobe", int'(dac_load), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_single(0, 12'h3C5, 3, 20);
    t_single(1, 12'hE01, 0, 0);
    t_single(1, 12'h000, 5, 60);
    t_reject();
    t_indep();
    t_contend();
    t_frozen();
    t_abort();
    t_single(0, 12'h9A9, 2, 4);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule